// File: doc/BRIEF.md
# Modem Control Input Change Detector

This block serves one serial channel and looks after its two active-low modem control lines: clear-to-send and carrier-detect. Each line is brought into the clock domain through a synchronizer. Any level change on a line, in either direction, is latched as a change flag. Each flag has its own mask bit, and the flags drive a shared interrupt. The synchronized lines also gate the channel: clear-to-send can enable the transmitter and carrier-detect can enable the receiver.

In ring-loop mode the clear-to-send pin turns around and becomes a loop-control output. Software commands assert and negate it, so the channel can join or leave the loop. In character-sync mode the carrier-detect line acts as an external sync input. Its assertion produces a one-cycle sync strobe for the receiver. Software reaches all of this through a small four-address register port with write-one-to-clear flags.

Top module: `modem_ctl_detect`

## Requirements
- R1: After a synchronous reset the control word and both change flags are zero and the loop-control state is negated. The outputs are then irq=0, lc_oe=0, lc_n_out=1, tx_en=1, rx_en=1 and sync_strobe=0.
- R2: Status (address 1) bit 0 reads 1 while the clear-to-send pin is low, and bit 1 reads 1 while the carrier-detect pin is low. A pin change shows in these bits SYNC_STAGES clock edges after it is set up.
- R3: A pin transition in either direction sets a change flag SYNC_STAGES+1 edges after the change. Clear-to-send sets status bit 2 and carrier-detect sets status bit 3.
- R4: A change flag stays set until software writes 1 to its bit at address 1. Writing 0 to the bit leaves the flag unchanged. If a new transition and the clearing write fall in the same cycle, the flag stays set.
- R5: irq is high exactly when a change flag is set and its mask bit is set. The clear-to-send mask is control bit 4 and the carrier-detect mask is control bit 5.
- R6: When control bit 0 is set and loop mode is off, tx_en follows the asserted state of clear-to-send. In every other case tx_en is 1.
- R7: When control bit 1 is set and sync mode (control bit 3) is off, rx_en follows the asserted state of carrier-detect. In every other case rx_en is 1.
- R8: Loop mode is control bit 2. In loop mode lc_oe=1 and lc_n_out is the inverse of the loop-control state; outside loop mode lc_n_out=1. A write to address 2 with bit 0 set asserts the state, and bit 1 set negates it; if both bits are set, negate wins. The state reads at status bit 4.
- R9: While loop mode is on, clear-to-send pin transitions do not set the change flag.
- R10: In sync mode, a falling carrier-detect pin gives a one-cycle sync_strobe SYNC_STAGES+1 edges later. A rising pin gives no strobe, and a falling pin outside sync mode gives none either.
- R11: Address 0 reads back all eight written control bits. Addresses 2 and 3 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cts_n_in | input | 1 | Clear-to-send pin, active low |
| dcd_n_in | input | 1 | Carrier-detect / external sync pin, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Masked change interrupt |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| lc_n_out | output | 1 | Loop-control drive onto the clear-to-send pin, active low |
| lc_oe | output | 1 | Output enable for the clear-to-send pin (loop mode) |
| sync_strobe | output | 1 | One-cycle external character-sync pulse |

## Verification
Two functions can land on a change flag in the same cycle: the detector setting it, and a software write-one-to-clear. The bench provokes this by changing a pin and then timing a clearing write so that it is sampled on the edge where the flag would set. It then judges that the flag reads 1 afterwards. A later plain clear with no transition shows the write itself still works. A second overlap is covered too: a clear-to-send transition that occurs while loop mode is on, which must be ignored even though the pin is still being sampled.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_CMD  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // control word, bit 0 is cts_gate
    typedef struct packed {
        logic [1:0] spare;
        logic       mask_dcd;
        logic       mask_cts;
        logic       sync_mode;
        logic       loop_mode;
        logic       dcd_gate;
        logic       cts_gate;
    } ctrl_t;

    localparam int STAT_CTS_CLR = 2;
    localparam int STAT_DCD_CLR = 3;
    localparam int CMD_ASSERT   = 0;
    localparam int CMD_NEGATE   = 1;

    function automatic logic [REG_W-1:0] pack_status(
        input logic cts_a, input logic dcd_a,
        input logic cts_c, input logic dcd_c, input logic lc);
        return {3'b000, lc, dcd_c, cts_c, dcd_a, cts_a};
    endfunction
endpackage

// File: rtl/mcd_pin_sync.sv
module mcd_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic change
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else if (i == 0) chain[i] <= pin;
                else chain[i] <= chain[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign level  = chain[STAGES-1];
    assign change = level ^ prev;

    // a reported change must be followed by a stable-looking prev
    p_change_tracks_r3: assert property (@(posedge clk) disable iff (rst)
        change |=> (prev == $past(level)));
endmodule

// File: rtl/mcd_regs.sv
module mcd_regs
    import mcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             cts_change,
    input  logic             dcd_change,
    input  logic             dcd_fall,
    output ctrl_t            ctrl,
    output logic             cts_chg,
    output logic             dcd_chg,
    output logic             lc_state,
    output logic             sync_strobe,
    output logic             irq
);
    logic wr_ctrl, wr_stat, wr_cmd;
    logic clr_cts, clr_dcd;

    assign wr_ctrl = we && (reg_addr_e'(addr) == ADDR_CTRL);
    assign wr_stat = we && (reg_addr_e'(addr) == ADDR_STAT);
    assign wr_cmd  = we && (reg_addr_e'(addr) == ADDR_CMD);
    assign clr_cts = wr_stat && wdata[STAT_CTS_CLR];
    assign clr_dcd = wr_stat && wdata[STAT_DCD_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= '0;
            cts_chg     <= 1'b0;
            dcd_chg     <= 1'b0;
            lc_state    <= 1'b0;
            sync_strobe <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata);
            // a new transition wins over a simultaneous clear
            cts_chg <= (cts_change && !ctrl.loop_mode) || (cts_chg && !clr_cts);
            dcd_chg <= dcd_change || (dcd_chg && !clr_dcd);
            if (wr_cmd) begin
                if (wdata[CMD_NEGATE])      lc_state <= 1'b0;
                else if (wdata[CMD_ASSERT]) lc_state <= 1'b1;
            end
            sync_strobe <= dcd_fall && ctrl.sync_mode;
        end
    end

    assign irq = (cts_chg && ctrl.mask_cts) || (dcd_chg && ctrl.mask_dcd);

    p_edge_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
        dcd_change |=> dcd_chg);
    p_flag_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (cts_chg && !clr_cts) |=> cts_chg);
    p_lc_only_by_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_cmd |=> $stable(lc_state));
    p_loop_blocks_cts_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.loop_mode && !cts_chg) |=> !cts_chg);
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
        sync_strobe |=> !sync_strobe);
    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cts_chg || dcd_chg));
endmodule

// File: rtl/modem_ctl_detect.sv
module modem_ctl_detect
    import mcd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_n_in,
    input  logic              dcd_n_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              tx_en,
    output logic              rx_en,
    output logic              lc_n_out,
    output logic              lc_oe,
    output logic              sync_strobe
);
    logic  cts_lvl, cts_change, dcd_lvl, dcd_change;
    logic  cts_asserted, dcd_asserted, dcd_fall;
    logic  cts_chg, dcd_chg, lc_state;
    ctrl_t ctrl;

    mcd_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
        .clk(clk), .rst(rst), .pin(cts_n_in), .level(cts_lvl), .change(cts_change));
    mcd_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dcd_sync (
        .clk(clk), .rst(rst), .pin(dcd_n_in), .level(dcd_lvl), .change(dcd_change));

    assign cts_asserted = !cts_lvl;
    assign dcd_asserted = !dcd_lvl;
    assign dcd_fall     = dcd_change && !dcd_lvl;

    mcd_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cts_change(cts_change), .dcd_change(dcd_change), .dcd_fall(dcd_fall),
        .ctrl(ctrl), .cts_chg(cts_chg), .dcd_chg(dcd_chg), .lc_state(lc_state),
        .sync_strobe(sync_strobe), .irq(irq));

    always_comb begin
        case (reg_addr_e'(reg_addr))
            ADDR_CTRL: reg_rdata = ctrl;
            ADDR_STAT: reg_rdata = pack_status(cts_asserted, dcd_asserted,
                                               cts_chg, dcd_chg, lc_state);
            default:   reg_rdata = '0;
        endcase
    end

    assign tx_en    = !(ctrl.cts_gate && !ctrl.loop_mode) || cts_asserted;
    assign rx_en    = !(ctrl.dcd_gate && !ctrl.sync_mode) || dcd_asserted;
    assign lc_oe    = ctrl.loop_mode;
    assign lc_n_out = !(ctrl.loop_mode && lc_state);

    p_oe_from_ctrl_write_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(lc_oe) |-> $past(reg_we && reg_addr == 2'd0 && reg_wdata[2]));
    p_rx_block_needs_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !rx_en |-> (ctrl.dcd_gate && !dcd_asserted));
    p_tx_open_in_loop_r6: assert property (@(posedge clk) disable iff (rst)
        lc_oe |-> tx_en);
endmodule

// File: tb/modem_ctl_detect_tb.sv
module modem_ctl_detect_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cts_n = 1'b1, dcd_n = 1'b1;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, tx_en, rx_en, lc_n_out, lc_oe, sync_strobe;
    int         n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    modem_ctl_detect u_dut (
        .clk(clk), .rst(rst), .cts_n_in(cts_n), .dcd_n_in(dcd_n),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .irq(irq), .tx_en(tx_en), .rx_en(rx_en), .lc_n_out(lc_n_out),
        .lc_oe(lc_oe), .sync_strobe(sync_strobe));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick(1);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd1, d); chk("R1 stat", d, 8'h00);
        chk("R1 outs", {2'b0, irq, lc_oe, lc_n_out, tx_en, rx_en, sync_strobe},
            8'b0000_1110);
    endtask

    task automatic t_levels_flags;
        logic [7:0] d;
        cts_n = 1'b0;
        tick(2); rd(2'd1, d); chk("R2 cts level", d, 8'h01);
        tick(1); rd(2'd1, d); chk("R3 cts fall flag", d, 8'h05);
        wr(2'd1, 8'h04); rd(2'd1, d); chk("R4 cts clear", d, 8'h01);
        cts_n = 1'b1; tick(3); rd(2'd1, d); chk("R3 cts rise flag", d, 8'h04);
        wr(2'd1, 8'h04);
        dcd_n = 1'b0; tick(2); rd(2'd1, d); chk("R2 dcd level", d, 8'h02);
        tick(1); rd(2'd1, d); chk("R3 dcd fall flag", d, 8'h0A);
        wr(2'd1, 8'h00); rd(2'd1, d); chk("R4 write zero keeps", d, 8'h0A);
        wr(2'd1, 8'h08);
        dcd_n = 1'b1; tick(3); rd(2'd1, d); chk("R3 dcd rise flag", d, 8'h08);
        wr(2'd1, 8'h08); rd(2'd1, d); chk("R4 dcd clear", d, 8'h00);
    endtask

    task automatic t_collision;
        logic [7:0] d;
        cts_n = 1'b0;
        tick(2);
        we = 1'b1; addr = 2'd1; wdata = 8'h04;
        tick(1);
        we = 1'b0;
        rd(2'd1, d); chk("R4 set beats clear", d, 8'h05);
        wr(2'd1, 8'h04); rd(2'd1, d); chk("R4 later clear", d, 8'h01);
        cts_n = 1'b1; tick(3); wr(2'd1, 8'h04);
    endtask

    task automatic t_irq;
        dcd_n = 1'b0; tick(3);
        chk("R5 masked off", {7'b0, irq}, 8'h00);
        wr(2'd0, 8'h10); chk("R5 wrong mask", {7'b0, irq}, 8'h00);
        wr(2'd0, 8'h20); chk("R5 dcd mask", {7'b0, irq}, 8'h01);
        wr(2'd1, 8'h08); chk("R5 cleared", {7'b0, irq}, 8'h00);
        dcd_n = 1'b1; tick(3); wr(2'd1, 8'h08); wr(2'd0, 8'h00);
    endtask

    task automatic t_gates;
        wr(2'd0, 8'h01); chk("R6 cts negated", {7'b0, tx_en}, 8'h00);
        cts_n = 1'b0; tick(2); chk("R6 cts asserted", {7'b0, tx_en}, 8'h01);
        cts_n = 1'b1; tick(3);
        wr(2'd0, 8'h02); chk("R7 dcd negated", {7'b0, rx_en}, 8'h00);
        chk("R6 gate off", {7'b0, tx_en}, 8'h01);
        dcd_n = 1'b0; tick(2); chk("R7 dcd asserted", {7'b0, rx_en}, 8'h01);
        dcd_n = 1'b1; tick(3);
        wr(2'd0, 8'h0A); chk("R7 sync mode bypass", {7'b0, rx_en}, 8'h01);
        wr(2'd0, 8'h00); wr(2'd1, 8'h0C);
    endtask

    task automatic t_loop;
        logic [7:0] d;
        wr(2'd0, 8'h05);
        chk("R8 oe", {6'b0, lc_oe, lc_n_out}, 8'h03);
        chk("R6 loop opens tx", {7'b0, tx_en}, 8'h01);
        wr(2'd2, 8'h01); chk("R8 assert", {7'b0, lc_n_out}, 8'h00);
        rd(2'd1, d); chk("R8 state read", d, 8'h10);
        wr(2'd2, 8'h00); chk("R8 empty cmd", {7'b0, lc_n_out}, 8'h00);
        wr(2'd2, 8'h03); chk("R8 negate wins", {7'b0, lc_n_out}, 8'h01);
        wr(2'd2, 8'h01);
        cts_n = 1'b0; tick(3); cts_n = 1'b1; tick(3);
        rd(2'd1, d); chk("R9 no cts flag", d, 8'h10);
        wr(2'd0, 8'h01);
        chk("R8 released", {6'b0, lc_oe, lc_n_out}, 8'h01);
        chk("R6 gate back", {7'b0, tx_en}, 8'h00);
        wr(2'd2, 8'h02); wr(2'd0, 8'h00);
    endtask

    task automatic t_sync;
        logic [7:0] seen;
        wr(2'd0, 8'h08);
        dcd_n = 1'b0; tick(2);
        chk("R10 not yet", {7'b0, sync_strobe}, 8'h00);
        tick(1); chk("R10 strobe", {7'b0, sync_strobe}, 8'h01);
        tick(1); chk("R10 one cycle", {7'b0, sync_strobe}, 8'h00);
        dcd_n = 1'b1; seen = 8'h00;
        for (int i = 0; i < 5; i++) begin tick(1); seen = seen | {7'b0, sync_strobe}; end
        chk("R10 rise none", seen, 8'h00);
        wr(2'd0, 8'h00);
        dcd_n = 1'b0; seen = 8'h00;
        for (int i = 0; i < 5; i++) begin tick(1); seen = seen | {7'b0, sync_strobe}; end
        chk("R10 off none", seen, 8'h00);
        dcd_n = 1'b1; tick(3); wr(2'd1, 8'h0C);
    endtask

    task automatic t_readmap;
        logic [7:0] d;
        wr(2'd0, 8'hC3); rd(2'd0, d); chk("R11 ctrl readback", d, 8'hC3);
        rd(2'd2, d); chk("R11 addr2 zero", d, 8'h00);
        rd(2'd3, d); chk("R11 addr3 zero", d, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        tick(3); rst = 1'b0; tick(1);
        t_reset();
        t_levels_flags();
        t_collision();
        t_irq();
        t_gates();
        t_loop();
        t_sync();
        t_readmap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule